// File: doc/BRIEF.md
# E1 Receive Spare-Bit Extractor

This block follows an E1 receive framer that already holds frame alignment. The framer feeds it one received bit at a time, together with a frame-start strobe and a flag that tells whether the frame starting on that bit carries the alignment word in timeslot 0. Every received bit is copied to a serial link output one cycle later. Alongside that copy the block drives a gated link clock and a frame-boundary marker. The link clock qualifies only the national spare bits that the host has enabled. The boundary marker flags the first bit of timeslot 0, which is where the international bit sits.

The block also keeps the two most recent timeslot-0 octets, one from the alignment frame and one from the non-alignment frame. Both octets are copied into host-readable registers at the same instant, on the first bit of an alignment frame. When that copy happens, a sticky status flag is set and an interrupt line is raised. The host must then read the registers within the next two frames (250 µs) before they are overwritten.

The framer cannot be stalled, so the bit stream has a valid strobe and no ready. The link output has no back-pressure either: a consumer must take each bit in the cycle where `link_valid` is high. A cycle with `rx_valid` low carries no bit and does not advance any state.

Top module: `e1_sa_extract`

## Requirements
- R1: Every bit accepted with `rx_valid` high appears unchanged on `link_data`, with `link_valid` high, exactly one clock later. `link_valid` is low one clock after any cycle in which `rx_valid` is low.
- R2: `link_clk` is high together with `link_valid` only for bit positions 4 to 8 of timeslot 0 in a non-alignment frame (bits numbered from 1 in arrival order), and only when the matching enable is set: `sa_mask[0]` enables bit 4 (Sa4) and so on up to `sa_mask[4]`, which enables bit 8 (Sa8). `link_clk` is never high in an alignment frame.
- R3: `link_fbound` pulses together with the output copy of bit 1 of every frame, which is the international (Si) bit. It is never high at the same time as `link_clk`.
- R4: The alignment register holds the timeslot-0 octet of an alignment frame, and the non-alignment register holds that of a non-alignment frame. In both, bit 1 of the timeslot is stored in register bit 7 and bit 8 in register bit 0.
- R5: The two registers change only together. They change only on a bit that has `rx_fstart` and `rx_fas` both high, and only after a complete timeslot 0 of each frame type has arrived since the previous update. At any other time they hold their contents.
- R6: An update sets the status flag, which reads back as bit 0 at address 2, and `irq` is high for as long as the flag is set.
- R7: A read of address 2 returns the flag and then clears it. If an update happens in the same cycle as that read, the read returns the old value and the flag stays set.
- R8: The read port returns data on `rd_data` one clock after `rd_en` is high. Address 0 selects the alignment register, address 1 the non-alignment register, address 2 the status, and address 3 reads as zero.
- R9: Before the first accepted `rx_fstart`, `link_clk` and `link_fbound` stay low and no octet is captured.
- R10: After reset, all outputs and both registers are zero.
- R11: If 256 bits pass without a frame-start strobe, the bit position wraps to bit 1 of a new frame, and the frame type alternates to the opposite kind.
- R12: Bits outside timeslot 0 have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received bit is present this cycle |
| rx_data | input | 1 | Received bit |
| rx_fstart | input | 1 | This bit is bit 1 of timeslot 0 |
| rx_fas | input | 1 | With `rx_fstart`: the new frame is an alignment frame |
| sa_mask | input | 5 | Spare-bit clock enables, Sa4 in bit 0 |
| link_valid | output | 1 | Link bit present |
| link_data | output | 1 | Copy of the received bit |
| link_clk | output | 1 | High on enabled spare-bit positions |
| link_fbound | output | 1 | High on the Si bit, which is bit 1 of each frame |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 2 | Host read address |
| rd_data | output | 8 | Read result, valid one clock after `rd_en` |
| irq | output | 1 | Level interrupt while the status flag is set |

## Verification
A bit-position counter that is off by one moves link-clock pulses onto the wrong bits and moves the boundary marker. The scoreboard catches this in the first enabled spare-bit position of the first non-alignment frame. A wrong frame-type record, or a wrong alternation after a missing frame-start strobe, either suppresses or creates clock pulses within one frame. It also puts the wrong octets in the registers, which shows up on the next host read. Faults in the pairing of the two captured octets show as an update that comes early, comes late or is missing, and the host sees this within two frames, in the status flag, in `irq` and in the register contents. Faults in flag priority show in the one cycle where a status read meets an update.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
  localparam int TS_BITS      = 8;
  localparam int SA_FIRST_POS = 3;
  localparam int RD_ADDR_W    = 2;
  localparam int REG_W        = 8;

  typedef enum logic [RD_ADDR_W-1:0] {
    SEL_ALIGN    = 2'd0,
    SEL_NONALIGN = 2'd1,
    SEL_STATUS   = 2'd2,
    SEL_SPARE    = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/e1_sa_pos.sv
module e1_sa_pos #(
  parameter int FRAME_BITS = 256,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             fstart,
  input  logic             fas_in,
  output logic [CNT_W-1:0] pos,
  output logic             frame_fas,
  output logic             locked
);
  logic [CNT_W-1:0] pos_q;
  logic             fas_q;
  logic             lock_q;

  // position and frame type of the bit presented this cycle
  always_comb begin
    if (fstart) begin
      pos       = '0;
      frame_fas = fas_in;
      locked    = 1'b1;
    end else if (pos_q == CNT_W'(FRAME_BITS - 1)) begin
      pos       = '0;
      frame_fas = ~fas_q;
      locked    = lock_q;
    end else begin
      pos       = pos_q + 1'b1;
      frame_fas = fas_q;
      locked    = lock_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= CNT_W'(FRAME_BITS - 1);
      fas_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (bit_valid) begin
      pos_q  <= pos;
      fas_q  <= frame_fas;
      lock_q <= locked;
    end
  end
endmodule

// File: rtl/e1_sa_link.sv
module e1_sa_link
  import e1_sa_pkg::*;
#(
  parameter int SA_BITS = 5,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_valid,
  input  logic               bit_data,
  input  logic [CNT_W-1:0]   pos,
  input  logic               frame_fas,
  input  logic               locked,
  input  logic [SA_BITS-1:0] sa_mask,
  output logic               link_valid,
  output logic               link_data,
  output logic               link_clk,
  output logic               link_fbound
);
  logic [SA_BITS-1:0] sa_hit;

  for (genvar i = 0; i < SA_BITS; i++) begin : g_sa
    assign sa_hit[i] = sa_mask[i] && (pos == CNT_W'(SA_FIRST_POS + i));
  end

  logic clk_next;
  logic bnd_next;
  assign clk_next = bit_valid && locked && !frame_fas && (|sa_hit);
  assign bnd_next = bit_valid && locked && (pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_valid  <= 1'b0;
      link_data   <= 1'b0;
      link_clk    <= 1'b0;
      link_fbound <= 1'b0;
    end else begin
      link_valid  <= bit_valid;
      link_data   <= bit_valid ? bit_data : 1'b0;
      link_clk    <= clk_next;
      link_fbound <= bnd_next;
    end
  end
endmodule

// File: rtl/e1_sa_capture.sv
module e1_sa_capture
  import e1_sa_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int IDX_W = $clog2(TS_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_data,
  input  logic             fstart,
  input  logic [CNT_W-1:0] pos,
  input  logic             frame_fas,
  input  logic             locked,
  output logic [REG_W-1:0] align_byte,
  output logic [REG_W-1:0] nonalign_byte,
  output logic             commit
);
  logic [REG_W-1:0] shadow_al;
  logic [REG_W-1:0] shadow_na;
  logic             done_al;
  logic             done_na;
  logic             in_ts0;
  logic             last_ts0;
  logic [IDX_W-1:0] bidx;

  assign in_ts0   = bit_valid && locked && (pos < CNT_W'(TS_BITS));
  assign last_ts0 = in_ts0 && (pos == CNT_W'(TS_BITS - 1));
  assign bidx     = IDX_W'(TS_BITS - 1) - pos[IDX_W-1:0];
  assign commit   = bit_valid && fstart && frame_fas && done_al && done_na;

  // shadow octets: filled bit by bit, first bit into the top position
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_al <= '0;
      shadow_na <= '0;
    end else if (in_ts0) begin
      if (frame_fas) shadow_al[bidx] <= bit_data;
      else           shadow_na[bidx] <= bit_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_al <= 1'b0;
      done_na <= 1'b0;
    end else if (commit) begin
      done_al <= 1'b0;
      done_na <= 1'b0;
    end else if (last_ts0) begin
      if (frame_fas) done_al <= 1'b1;
      else           done_na <= 1'b1;
    end
  end

  // both host copies move together on the alignment-frame boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      align_byte    <= '0;
      nonalign_byte <= '0;
    end else if (commit) begin
      align_byte    <= shadow_al;
      nonalign_byte <= shadow_na;
    end
  end
endmodule

// File: rtl/e1_sa_host.sv
module e1_sa_host
  import e1_sa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  input  logic [REG_W-1:0]     align_byte,
  input  logic [REG_W-1:0]     nonalign_byte,
  input  logic                 commit,
  output logic [REG_W-1:0]     rd_data,
  output logic                 irq
);
  logic flag_q;
  logic flag_d;
  logic status_rd;

  assign status_rd = rd_en && (rd_sel_e'(rd_addr) == SEL_STATUS);

  // a new update outranks the clear from a status read
  always_comb begin
    flag_d = flag_q;
    if (status_rd) flag_d = 1'b0;
    if (commit)    flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_sel_e'(rd_addr))
        SEL_ALIGN:    rd_data <= align_byte;
        SEL_NONALIGN: rd_data <= nonalign_byte;
        SEL_STATUS:   rd_data <= {{(REG_W-1){1'b0}}, flag_q};
        default:      rd_data <= '0;
      endcase
    end
  end

  assign irq = flag_q;
endmodule

// File: rtl/e1_sa_extract.sv
module e1_sa_extract
  import e1_sa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SA_BITS    = 5,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid,
  input  logic                 rx_data,
  input  logic                 rx_fstart,
  input  logic                 rx_fas,
  input  logic [SA_BITS-1:0]   sa_mask,
  output logic                 link_valid,
  output logic                 link_data,
  output logic                 link_clk,
  output logic                 link_fbound,
  input  logic                 rd_en,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]     rd_data,
  output logic                 irq
);
  logic [CNT_W-1:0] pos_w;
  logic             fas_w;
  logic             lock_w;
  logic             fstart_w;
  logic [REG_W-1:0] al_w;
  logic [REG_W-1:0] na_w;
  logic             commit_w;

  assign fstart_w = rx_valid && rx_fstart;

  e1_sa_pos #(.FRAME_BITS(FRAME_BITS)) u_pos (
    .clk(clk), .rst_n(rst_n), .bit_valid(rx_valid), .fstart(fstart_w),
    .fas_in(rx_fas), .pos(pos_w), .frame_fas(fas_w), .locked(lock_w)
  );

  e1_sa_link #(.SA_BITS(SA_BITS), .CNT_W(CNT_W)) u_link (
    .clk(clk), .rst_n(rst_n), .bit_valid(rx_valid), .bit_data(rx_data),
    .pos(pos_w), .frame_fas(fas_w), .locked(lock_w), .sa_mask(sa_mask),
    .link_valid(link_valid), .link_data(link_data), .link_clk(link_clk),
    .link_fbound(link_fbound)
  );

  e1_sa_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .bit_valid(rx_valid), .bit_data(rx_data),
    .fstart(fstart_w), .pos(pos_w), .frame_fas(fas_w), .locked(lock_w),
    .align_byte(al_w), .nonalign_byte(na_w), .commit(commit_w)
  );

  e1_sa_host u_host (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .align_byte(al_w), .nonalign_byte(na_w), .commit(commit_w),
    .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: rtl/e1_sa_chk.sv
module e1_sa_chk
  import e1_sa_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_valid,
  input logic                 rx_data,
  input logic                 link_valid,
  input logic                 link_data,
  input logic                 link_clk,
  input logic                 link_fbound,
  input logic                 rd_en,
  input logic [RD_ADDR_W-1:0] rd_addr,
  input logic                 irq,
  input logic                 commit,
  input logic [REG_W-1:0]     align_byte,
  input logic [REG_W-1:0]     nonalign_byte
);
  assert_link_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (link_valid && link_data == $past(rx_data)));

  assert_link_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !link_valid);

  assert_clk_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    link_clk |-> link_valid);

  assert_bound_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_fbound |-> !link_clk);

  assert_regs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(align_byte) && $stable(nonalign_byte)));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd2 && !commit) |=> !irq);
endmodule

bind e1_sa_extract e1_sa_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .link_valid(link_valid), .link_data(link_data), .link_clk(link_clk),
  .link_fbound(link_fbound), .rd_en(rd_en), .rd_addr(rd_addr), .irq(irq),
  .commit(commit_w), .align_byte(al_w), .nonalign_byte(na_w)
);

// File: tb/sim_e1_sa_extract.sv
`timescale 1ns/1ps
module sim_e1_sa_extract;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_data = 1'b0, rx_fstart = 1'b0, rx_fas = 1'b0;
  logic [4:0] sa_mask = '0;
  logic       link_valid, link_data, link_clk, link_fbound;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  always #5 clk = ~clk;

  e1_sa_extract u0 (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct packed { logic d; logic c; logic f; } exp_t;
  exp_t q[$];

  // independent bench model of frame position
  bit m_lock = 0;
  int m_pos = 255;
  bit m_fas = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] snap_rd;
  logic       snap_irq;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic d, input logic fs, input logic fas, input logic rdst);
    exp_t e;
    @(negedge clk);
    snap_rd = rd_data; snap_irq = irq;
    rx_valid = 1'b1; rx_data = d; rx_fstart = fs; rx_fas = fas;
    rd_en = rdst; rd_addr = 2'd2;
    if (fs) begin m_pos = 0; m_fas = fas; m_lock = 1; end
    else if (m_pos == 255) begin m_pos = 0; m_fas = !m_fas; end
    else m_pos = m_pos + 1;
    e.d = d;
    e.f = m_lock && (m_pos == 0);
    e.c = m_lock && !m_fas && m_pos >= 3 && m_pos <= 7 && sa_mask[m_pos-3];
    q.push_back(e);
  endtask

  task automatic send_idle();
    @(negedge clk);
    rx_valid = 1'b0; rx_fstart = 1'b0; rd_en = 1'b0;
  endtask

  task automatic send_frame(input logic fas, input logic [7:0] ts0,
                            input bit use_fs, input bit gaps, input bit rd0);
    for (int i = 0; i < 256; i++) begin
      logic d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d = (i < 8) ? ts0[7-i] : lfsr[0];
      send_bit(d, use_fs && i == 0, fas, rd0 && i == 0);
      if (rd0 && i == 1) begin
        chk("R7 status read meeting update returns old flag", snap_rd, 0);
        chk("R7 update wins over clear", snap_irq, 1);
      end
      if (gaps && (i % 37 == 36)) send_idle();
    end
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rx_valid = 1'b0; rx_fstart = 1'b0; rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && link_valid) begin
      if (q.size() == 0) begin
        chk("R1 unexpected link bit", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R1 link data", link_data, e.d);
        chk("R2 link clock gating", link_clk, e.c);
        chk("R3 frame boundary marker", link_fbound, e.f);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 link_valid after reset", link_valid, 0);
    chk("R10 link_clk after reset", link_clk, 0);
    chk("R10 irq after reset", irq, 0);
    do_read(2'd0, v); chk("R10 align reg reset", v, 8'h00);
    do_read(2'd1, v); chk("R10 nonalign reg reset", v, 8'h00);
    do_read(2'd2, v); chk("R10 status reset", v, 8'h00);

    sa_mask = 5'b10101;
    for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b0, 1'b0, 1'b0);
    send_idle();
    do_read(2'd2, v); chk("R9 no update before lock", v, 0);
    do_read(2'd1, v); chk("R9 no capture before lock", v, 8'h00);

    send_frame(1'b1, 8'h9B, 1, 0, 0);
    send_frame(1'b0, 8'hD6, 1, 0, 0);
    send_idle();
    do_read(2'd2, v); chk("R5 no update before boundary", v, 0);
    do_read(2'd0, v); chk("R5 align reg held", v, 8'h00);

    sa_mask = 5'b01010;
    send_frame(1'b1, 8'h1B, 1, 1, 0);
    send_idle();
    chk("R6 irq set after update", irq, 1);
    do_read(2'd2, v); chk("R6 status flag set", v, 1);
    chk("R7 irq cleared by status read", irq, 0);
    do_read(2'd2, v); chk("R7 status flag cleared", v, 0);
    do_read(2'd0, v); chk("R4 R12 align octet", v, 8'h9B);
    do_read(2'd1, v); chk("R4 R12 nonalign octet", v, 8'hD6);
    do_read(2'd3, v); chk("R8 spare address reads zero", v, 8'h00);

    sa_mask = 5'b11111;
    send_frame(1'b0, 8'h5F, 1, 0, 0);
    send_idle();
    do_read(2'd0, v); chk("R5 align reg held until boundary", v, 8'h9B);

    send_frame(1'b1, 8'h9B, 1, 0, 1);
    send_idle();
    do_read(2'd0, v); chk("R4 align octet second pair", v, 8'h1B);
    do_read(2'd1, v); chk("R4 nonalign octet second pair", v, 8'h5F);
    do_read(2'd2, v); chk("R6 flag set by second update", v, 1);

    // wrap without frame start: type alternates
    send_frame(1'b0, 8'hC0, 1, 0, 0);
    send_frame(1'b0, 8'h1B, 0, 0, 0);
    send_frame(1'b0, 8'hFF, 0, 0, 0);
    send_frame(1'b1, 8'h9B, 1, 0, 0);
    send_idle();
    do_read(2'd0, v); chk("R11 wrapped frame seen as alignment", v, 8'h1B);
    do_read(2'd1, v); chk("R11 next wrapped frame seen as nonalignment", v, 8'hFF);

    send_idle(); send_idle();
    chk("R1 all link bits delivered", q.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule